// File: doc/BRIEF.md
# Folded Odd-Word Table Multiplier With Signed Output

The block multiplies an unsigned 7-bit operand X by a signed two's-complement coefficient. The coefficient is fixed when the design is elaborated. There is no hardware multiplier. A small read-only table holds negated odd multiples of the odd part of the coefficient. A folding address generator maps X onto one table entry and a shift count.

Folding works like this:
- The low six bits of X are taken either directly or as their two's complement, chosen by the top bit of X.
- The trailing zeros of that folded value give the shift count.
- The remaining odd part selects the table entry.

Each stored word except the last is odd. Negation of the table output is therefore a cheap operation: bit 0 passes through and every higher bit is inverted. This negation applies only when the top bit of X is set. The result is shifted by the per-operand count and then by a fixed shift equal to the power of two in the coefficient. A constant of 64 times the coefficient is added to form the product.

The product is registered. It appears two clock cycles after X is sampled, at a rate of one operand per cycle.

Top module: `odd_table_mult`

## Requirements
- R1: For an odd positive coefficient, the output equals COEF·X as a signed W+7-bit value. The result for the X sampled at a rising edge appears after the second following edge, one new X per cycle.
- R2: While rst is high at a rising edge, the output becomes zero on that edge (synchronous, active high).
- R3: X = 0 gives a product of zero. This case uses the single even table word, shifted left by 5.
- R4: X = 64 (only bit 6 set) gives exactly 64·COEF. The table output is forced to zero for this operand.
- R5: Every table word at an index below 32 is odd. It is negated only when bit 6 of X is 1, by keeping bit 0 and inverting all higher bits.
- R6: A nonzero even coefficient COEF = A'·2^l with A' odd gives an exact product. The table holds multiples of A', and a fixed left shift by l restores the scale.
- R7: A negative coefficient, odd or even, gives an exact two's-complement product for all 128 values of X.
- R8: COEF = 0 gives an output that is always zero.
- R9: The table index never exceeds 32 and the per-operand shift never exceeds 5. Index 32 occurs only together with a shift of 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| x | input | 7 | Unsigned multiplier operand |
| prod | output | W+7 | Signed product COEF·x, two cycles after x is sampled |

## Verification
An incorrect fold, shift count or table word corrupts the product only for the X values that reach that entry. For this reason the bench sweeps all 128 operands for five coefficients: odd positive, odd negative, even positive, the most negative even value, and zero. A wrong entry shows as a wrong product exactly two cycles after the offending X is applied. A stray negation of the even word shows only at X = 0, and a missing clear shows only at X = 64, so both operands are also applied on their own. Random operands follow, so the pipeline also carries back-to-back distinct inputs.

// File: rtl/oddw_pkg.sv
package oddw_pkg;

  // number of trailing zero bits of a nonzero value (0 for zero)
  function automatic int trail_zeros(int v);
    int n;
    int t;
    n = 0;
    t = v;
    if (t == 0) return 0;
    while (((t & 1) == 0) && (n < 31)) begin
      t = t >>> 1;
      n++;
    end
    return n;
  endfunction

  // odd factor of a value after removing its powers of two
  function automatic int odd_factor(int v);
    return v >>> trail_zeros(v);
  endfunction

endpackage

// File: rtl/oddw_addr_gen.sv
module oddw_addr_gen #(
  parameter int L  = 7,
  parameter int AW = L - 1,
  parameter int SW = $clog2(AW)
) (
  input  logic [L-1:0]  x,
  output logic [AW-1:0] idx,
  output logic [SW-1:0] sh,
  output logic          neg,
  output logic          blank
);
  localparam int SPECIAL = 1 << (AW - 1);

  logic [AW-1:0] low, fold, odd;
  logic          found;

  always_comb begin
    low   = x[AW-1:0];
    neg   = x[L-1];
    fold  = neg ? low : (~low + 1'b1);
    blank = neg && (low == '0);
    sh    = '0;
    found = 1'b0;
    for (int i = 0; i < AW; i++) begin
      if (!found && fold[i]) begin
        sh    = SW'(i);
        found = 1'b1;
      end
    end
    odd = fold >> sh;
    if (fold == '0) begin
      idx = AW'(SPECIAL);
      sh  = SW'(AW - 1);
    end else begin
      idx = odd >> 1;
    end
  end

  always_comb begin
    if (!$isunknown(x)) begin
      assert_idx_range_R9: assert (idx <= AW'(SPECIAL));
      assert_shift_range_R9: assert (sh <= SW'(AW - 1));
      assert_special_shift_R9: assert ((idx != AW'(SPECIAL)) || (sh == SW'(AW - 1)));
    end
  end
endmodule

// File: rtl/oddw_rom.sv
module oddw_rom #(
  parameter int W   = 12,
  parameter int L   = 7,
  parameter int ODD = 1,
  parameter int D   = W + L - 1,
  parameter int IW  = L - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  output logic [D-1:0]  word
);
  localparam int HALF = 1 << (L - 2);
  localparam int N    = HALF + 1;

  logic [D-1:0]  mem [N];
  logic [IW-1:0] idx_q;

  // negated odd multiples, then the negated doubled word for X = 0
  initial begin
    for (int i = 0; i < HALF; i++) mem[i] = D'(-(ODD * (2 * i + 1)));
    mem[HALF] = D'(-(2 * ODD));
  end

  always_ff @(posedge clk) begin
    word  <= mem[idx];
    idx_q <= idx;
  end

  assert_odd_word_R5: assert property (@(posedge clk) disable iff (rst)
    (idx_q < IW'(HALF)) |-> word[0]);
endmodule

// File: rtl/oddw_post.sv
module oddw_post #(
  parameter int W    = 12,
  parameter int L    = 7,
  parameter int LSH  = 0,
  parameter int COEF = 1,
  parameter int D    = W + L - 1,
  parameter int SW   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [D-1:0]          word,
  input  logic                  neg,
  input  logic                  blank,
  input  logic [SW-1:0]         sh,
  output logic signed [W+L-1:0] prod
);
  localparam int PW = W + L + 1;
  localparam logic [PW-1:0] BASE = PW'(COEF * (1 << (L - 1)));

  logic [D-1:0]  flip, pick;
  logic [PW-1:0] ext, scaled, sum;

  always_comb begin
    flip   = {~word[D-1:1], word[0]};
    pick   = blank ? '0 : (neg ? flip : word);
    ext    = {{(PW - D){pick[D-1]}}, pick};
    scaled = (ext << sh) << LSH;
    sum    = BASE + scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= sum[W+L-1:0];
  end

  assert_flip_odd_R5: assert property (@(posedge clk) disable iff (rst)
    (neg && !blank) |-> word[0]);
  assert_blank_top_R4: assert property (@(posedge clk) disable iff (rst)
    blank |-> neg);
endmodule

// File: rtl/odd_table_mult.sv
module odd_table_mult #(
  parameter int W    = 12,
  parameter int COEF = 1173
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [6:0]          x,
  output logic signed [W+6:0] prod
);
  localparam int L   = 7;
  localparam int AW  = L - 1;
  localparam int SW  = $clog2(AW);
  localparam int D   = W + L - 1;
  localparam int LSH = oddw_pkg::trail_zeros(COEF);
  localparam int ODD = oddw_pkg::odd_factor(COEF);

  generate
    if (COEF == 0) begin : g_zero
      always_ff @(posedge clk) prod <= '0;
      assert_zero_coef_R8: assert property (@(posedge clk) prod == '0);
    end else begin : g_table
      logic [AW-1:0] idx;
      logic [SW-1:0] sh, sh_q;
      logic          neg, blank, neg_q, blank_q;
      logic [D-1:0]  word;

      oddw_addr_gen #(.L(L), .AW(AW), .SW(SW)) i_addr (
        .x(x), .idx(idx), .sh(sh), .neg(neg), .blank(blank));

      oddw_rom #(.W(W), .L(L), .ODD(ODD), .D(D), .IW(AW)) i_rom (
        .clk(clk), .rst(rst), .idx(idx), .word(word));

      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0; neg_q <= 1'b0; blank_q <= 1'b0;
        end else begin
          sh_q <= sh; neg_q <= neg; blank_q <= blank;
        end
      end

      oddw_post #(.W(W), .L(L), .LSH(LSH), .COEF(COEF), .D(D), .SW(SW)) i_post (
        .clk(clk), .rst(rst), .word(word), .neg(neg_q), .blank(blank_q),
        .sh(sh_q), .prod(prod));
    end
  endgenerate

  // pipeline fill tracker used only by the end-to-end checks
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 2'd2) live <= live + 2'd1;
  end

  assert_reset_R2: assert property (@(posedge clk) $past(rst) |-> (prod == '0));
  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2) |-> (int'(prod) == COEF * int'($past(x, 2))));
  assert_x_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ((live == 2'd2) && ($past(x, 2) == 7'd0)) |-> (prod == '0));
  assert_x_half_R4: assert property (@(posedge clk) disable iff (rst)
    ((live == 2'd2) && ($past(x, 2) == 7'd64)) |-> (int'(prod) == COEF * 64));
endmodule

// File: tb/test_odd_table_mult.sv
module test_odd_table_mult;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst;
  logic [6:0] x;
  logic signed [W+6:0] p_odd, p_neg, p_even, p_min, p_zero;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  odd_table_mult #(.W(W), .COEF(1173))  i_odd_table_mult (.clk(clk), .rst(rst), .x(x), .prod(p_odd));
  odd_table_mult #(.W(W), .COEF(-1365)) i_odd_table_mult_neg (.clk(clk), .rst(rst), .x(x), .prod(p_neg));
  odd_table_mult #(.W(W), .COEF(40))    i_odd_table_mult_even (.clk(clk), .rst(rst), .x(x), .prod(p_even));
  odd_table_mult #(.W(W), .COEF(-2048)) i_odd_table_mult_min (.clk(clk), .rst(rst), .x(x), .prod(p_min));
  odd_table_mult #(.W(W), .COEF(0))     i_odd_table_mult_zero (.clk(clk), .rst(rst), .x(x), .prod(p_zero));

  function automatic int expect_prod(int a, int xv);
    return a * xv;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(string tag, int xv);
    check({tag, " R1 odd"},  int'(p_odd),  expect_prod(1173, xv));
    check({tag, " R7 neg"},  int'(p_neg),  expect_prod(-1365, xv));
    check({tag, " R6 even"}, int'(p_even), expect_prod(40, xv));
    check({tag, " R7 min"},  int'(p_min),  expect_prod(-2048, xv));
    check({tag, " R8 zero"}, int'(p_zero), 0);
  endtask

  task automatic run_vec(int xv, string tag);
    @(negedge clk) x = 7'(xv);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_all(tag, xv);
  endtask

  task automatic main_seq();
    rst = 1'b1;
    x = '0;
    repeat (3) @(negedge clk);
    check_all("R2 reset", 0);
    @(negedge clk) rst = 1'b0;
    run_vec(0,   "R3 x=0");
    run_vec(64,  "R4 x=64");
    run_vec(127, "R1 x=127");
    run_vec(1,   "R5 x=1");
    run_vec(63,  "R5 x=63");
    run_vec(65,  "R5 x=65");
    run_vec(32,  "R9 x=32");
    run_vec(96,  "R9 x=96");
    for (int v = 0; v < 128; v++) run_vec(v, "sweep");
    void'($urandom(32'd7351));
    for (int k = 0; k < 150; k++) run_vec(int'($urandom % 128), "random");
    // mid-run reset clears the output
    @(negedge clk) begin x = 7'd127; rst = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    check_all("R2 midreset", 0);
    @(negedge clk) rst = 1'b0;
    run_vec(64, "R4 after reset");
  endtask

  initial begin
    fork
      main_seq();
      begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule